// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block drives and observes up to 32 general-purpose pad lines through a word-addressed register bus. Each line owns one control word. That word decides whether the line drives its pad and whether it samples the pad. It also decides whether the line may raise an interrupt, and which condition on the pad counts as an interrupt event.

Pad inputs are brought into the clock domain by a two-stage synchroniser. A per-line detector then turns the synchronised value into an event. The event can be a level of either polarity, or an edge in one or both directions. Events set sticky pending bits, which software reads from a shared status word and clears by writing ones.

Interrupts leave the block in two forms. One is a vector with one bit per line. The other is a single line that is high whenever any bit of that vector is high. Routing these to a platform interrupt controller is left to the surrounding system.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The control word of line i sits at byte address 4*i. It holds eight bits: bit 0 output enable, bit 1 input enable, bit 2 output buffer enable, bit 3 interrupt enable, bit 4 output level, bits [7:5] trigger code. Bits above 7 ignore writes and read as 0.
- R2: pad_oe[i] is high only when both output enable and output buffer enable of line i are set. pad_out[i] equals the output level bit while output enable is set, and is 0 otherwise.
- R3: A read of byte address 0x84 returns the synchronised pad inputs ANDed with each line's input enable. A pad change shows there after the second rising clock edge.
- R4: The trigger code selects the event that sets a line's pending bit: 0 level high, 1 level low, 2 rising edge, 3 falling edge, 4 either edge; codes 5 to 7 never set it. An edge on the pad sets the pending bit at the third rising clock edge after the pad changes.
- R5: In the level modes, the pending bit is set again on every cycle the active level remains. A clear written while the level persists leaves the bit at 1.
- R6: A read of byte address 0x80 returns the pending bits, bit i for line i. A write there clears each pending bit whose data bit is 1 and leaves the others unchanged.
- R7: When an event and a clear of the same pending bit land on the same clock edge, the bit ends up set.
- R8: A line whose interrupt enable is 0 never sets its pending bit, and never drives its irq_vec bit, even if that bit was left pending.
- R9: irq_vec[i] is high when line i is pending and its interrupt enable is set. irq_any is the OR of all irq_vec bits.
- R10: A synchronous active-low reset clears all control words, pending bits and synchroniser stages, so no pad is driven and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | N_LINES | Asynchronous pad inputs |
| pad_out | output | N_LINES | Pad output values |
| pad_oe | output | N_LINES | Pad output drive enables |
| irq_vec | output | N_LINES | Per-line interrupt requests |
| irq_any | output | 1 | OR of all line interrupt requests |

## Verification
The bench times each edge event to the exact clock edge. A detector that skips or adds a stage shows up as a pending bit one cycle early or late. It clears a bit on the same edge that a fresh rising edge arrives, which catches a design that lets the clear win and loses the event. It writes clears during a held active level, which exposes a level mode that latches only once. It also writes zeros to the status word, disables an already-pending line, and uses undefined trigger codes. A design that clears on zero, leaks a masked bit to irq_vec or decodes a spare code as an edge would fail those checks.

// File: rtl/gpio_pkg.sv
// Shared definitions for the interrupt-capable GPIO controller.
// Assumes a 32-bit register bus and byte addresses with word stride.
package gpio_pkg;

    localparam int DATA_W  = 32;
    localparam int CTRL_W  = 8;
    localparam int TRIG_W  = 3;

    // Trigger codes held in control bits [7:5]
    localparam logic [TRIG_W-1:0] TRIG_LVL_HI = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_LVL_LO = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_RISE   = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_FALL   = 3'd3;
    localparam logic [TRIG_W-1:0] TRIG_BOTH   = 3'd4;

    // Byte offsets of the shared words
    localparam int STATUS_OFS = 'h80;
    localparam int INPUT_OFS  = 'h84;

    // Per-line control word, MSB first
    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              out_lvl;
        logic              irq_en;
        logic              buf_en;
        logic              in_en;
        logic              out_en;
    } line_ctrl_t;

endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is an independent slow signal; no bus coherence is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift pad values through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_trig_detect.sv
// Per-line event detector: compares the synchronised value with its value one
// cycle earlier and applies the line's trigger code. Assumes inputs are
// already synchronous.
module gpio_trig_detect
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cur_in,
    input  logic [W*TRIG_W-1:0] trig_flat,
    output logic [W-1:0]      evt
);

    logic [W-1:0] prev_q;

    // Remember last cycle's synchronised input
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [TRIG_W-1:0] code;
        assign code = trig_flat[i*TRIG_W +: TRIG_W];

        // Select the event condition for this line
        always_comb begin
            unique case (code)
                TRIG_LVL_HI: evt[i] = cur_in[i];
                TRIG_LVL_LO: evt[i] = ~cur_in[i];
                TRIG_RISE:   evt[i] = cur_in[i] & ~prev_q[i];
                TRIG_FALL:   evt[i] = ~cur_in[i] & prev_q[i];
                TRIG_BOTH:   evt[i] = cur_in[i] ^ prev_q[i];
                default:     evt[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_pending.sv
// Sticky pending-bit store with write-one-to-clear; a set on the same edge
// as a clear wins. Assumes set and clr are synchronous one-cycle pulses.
module gpio_pending #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    logic [W-1:0] pend_q;

    // Apply clear, then set, to each pending bit
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | set;
    end

    assign pend = pend_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);                                   // R7
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]);                     // R6
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);                     // R6
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend[i] && !set[i]) |=> !pend[i]);                   // R4
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: per-line control words, pad drive, synchronised input
// readback, event detection and pending storage with two interrupt outputs.
// Assumes N_LINES <= 32 and ADDR_W >= 8; reads are combinational.
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_LINES-1:0] pad_in,
    output logic [N_LINES-1:0] pad_out,
    output logic [N_LINES-1:0] pad_oe,
    output logic [N_LINES-1:0] irq_vec,
    output logic              irq_any
);

    localparam int TFLAT_W = N_LINES * TRIG_W;

    line_ctrl_t          ctrl_q [N_LINES];
    logic [N_LINES-1:0]  hit_ctrl;
    logic                hit_stat;
    logic                hit_in;
    logic                wr_en;
    logic [N_LINES-1:0]  sync_in;
    logic [N_LINES-1:0]  evt;
    logic [N_LINES-1:0]  irq_en_v;
    logic [N_LINES-1:0]  in_en_v;
    logic [N_LINES-1:0]  pend;
    logic [N_LINES-1:0]  set_v;
    logic [N_LINES-1:0]  clr_v;
    logic [TFLAT_W-1:0]  trig_flat;

    assign wr_en    = bus_sel & bus_wr;
    assign hit_stat = bus_sel && (bus_addr == ADDR_W'(STATUS_OFS));
    assign hit_in   = bus_sel && (bus_addr == ADDR_W'(INPUT_OFS));

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign hit_ctrl[i] = bus_sel && (bus_addr == ADDR_W'(4 * i));

        // Hold the line's control word
        always_ff @(posedge clk) begin
            if (!rst_n)                     ctrl_q[i] <= '0;
            else if (wr_en && hit_ctrl[i])  ctrl_q[i] <= line_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end

        assign pad_oe[i]  = ctrl_q[i].out_en & ctrl_q[i].buf_en;
        assign pad_out[i] = ctrl_q[i].out_en & ctrl_q[i].out_lvl;
        assign irq_en_v[i] = ctrl_q[i].irq_en;
        assign in_en_v[i]  = ctrl_q[i].in_en;
        assign trig_flat[i*TRIG_W +: TRIG_W] = ctrl_q[i].trig;
    end

    gpio_sync #(.W(N_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_in)
    );

    gpio_trig_detect #(.W(N_LINES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_in    (sync_in),
        .trig_flat (trig_flat),
        .evt       (evt)
    );

    assign set_v = evt & irq_en_v;
    assign clr_v = (wr_en && hit_stat) ? bus_wdata[N_LINES-1:0] : '0;

    gpio_pending #(.W(N_LINES)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .pend  (pend)
    );

    assign irq_vec = pend & irq_en_v;
    assign irq_any = |irq_vec;

    // Read-data mux for control, status and input words
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (hit_ctrl[i]) bus_rdata = DATA_W'(ctrl_q[i]);
        end
        if (hit_stat) bus_rdata = DATA_W'(pend);
        if (hit_in)   bus_rdata = DATA_W'(sync_in & in_en_v);
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(irq_en_v[i]));                // R8
    end
    AST_ANY_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (pend != '0));                                  // R9

endmodule

// File: tb/gpio_irq_ctrl_test.sv
// Directed bench for gpio_irq_ctrl; one task per scenario.
module gpio_irq_ctrl_test;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic [N-1:0] irq_vec;
    logic        irq_any;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.N_LINES(N), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_vec(irq_vec), .irq_any(irq_any)
    );

    localparam logic [7:0] STAT = 8'h80;
    localparam logic [7:0] INP  = 8'h84;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Control word: trig[7:5] lvl[4] irq_en[3] buf_en[2] in_en[1] out_en[0]
    function automatic logic [31:0] cw(input int trig, input bit lvl, input bit ien,
                                       input bit buf_en, input bit inen, input bit oe);
        return {24'd0, 3'(trig), lvl, ien, buf_en, inen, oe};
    endfunction

    function automatic logic [7:0] caddr(input int line);
        return 8'(4 * line);
    endfunction

    // Called at a negedge; commits on the next posedge, returns at negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] bit_of(input logic [31:0] v, input int line);
        return {31'd0, v[line]};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(caddr(0), d);  check("R10 ctrl after reset", d, 32'd0);
        rd(STAT, d);      check("R10 status after reset", d, 32'd0);
        check("R10 pad_oe after reset", pad_oe, 32'd0);
        check("R10 irq_any after reset", {31'd0, irq_any}, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(caddr(3), 32'hFFFF_FFFF);
        rd(caddr(3), d);  check("R1 upper bits read zero", d, 32'h0000_00FF);
        wr(caddr(31), 32'h0000_005A);
        rd(caddr(31), d); check("R1 line 31 readback", d, 32'h0000_005A);
        rd(caddr(30), d); check("R1 neighbour untouched", d, 32'd0);
        wr(caddr(3), 32'd0);
        wr(caddr(31), 32'd0);
    endtask

    task automatic t_pads();
        wr(caddr(2), cw(0, 1, 0, 1, 0, 1));
        check("R2 oe with buffer", bit_of(pad_oe, 2), 32'd1);
        check("R2 out level", bit_of(pad_out, 2), 32'd1);
        wr(caddr(2), cw(0, 1, 0, 0, 0, 1));
        check("R2 oe without buffer", bit_of(pad_oe, 2), 32'd0);
        wr(caddr(2), cw(0, 1, 0, 1, 0, 0));
        check("R2 out gated by oe", bit_of(pad_out, 2), 32'd0);
        check("R2 oe gated", bit_of(pad_oe, 2), 32'd0);
        wr(caddr(2), 32'd0);
    endtask

    task automatic t_input();
        logic [31:0] d;
        wr(caddr(7), cw(0, 0, 0, 0, 1, 0));
        pad_in[7] = 1'b1;
        edges(1);
        rd(INP, d); check("R3 input after one edge", bit_of(d, 7), 32'd0);
        edges(1);
        rd(INP, d); check("R3 input after two edges", bit_of(d, 7), 32'd1);
        wr(caddr(7), 32'd0);
        rd(INP, d); check("R3 input masked by enable", bit_of(d, 7), 32'd0);
        pad_in[7] = 1'b0;
        edges(3);
    endtask

    task automatic t_rising();
        logic [31:0] d;
        wr(caddr(10), cw(2, 0, 1, 0, 0, 0));
        pad_in[10] = 1'b1;
        edges(2);
        rd(STAT, d); check("R4 rising not yet", bit_of(d, 10), 32'd0);
        edges(1);
        rd(STAT, d); check("R4 rising on third edge", bit_of(d, 10), 32'd1);
        check("R9 irq_vec line 10", bit_of(irq_vec, 10), 32'd1);
        wr(STAT, 32'd1 << 10);
        pad_in[10] = 1'b0;
        edges(4);
        rd(STAT, d); check("R4 rising ignores fall", bit_of(d, 10), 32'd0);
        wr(caddr(10), 32'd0);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        wr(caddr(11), cw(3, 0, 1, 0, 0, 0));
        pad_in[11] = 1'b1;
        edges(4);
        rd(STAT, d); check("R4 falling ignores rise", bit_of(d, 11), 32'd0);
        pad_in[11] = 1'b0;
        edges(3);
        rd(STAT, d); check("R4 falling detected", bit_of(d, 11), 32'd1);
        wr(STAT, 32'd1 << 11);
        wr(caddr(11), 32'd0);
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(caddr(12), cw(4, 0, 1, 0, 0, 0));
        pad_in[12] = 1'b1;
        edges(3);
        rd(STAT, d); check("R4 both-edge rise", bit_of(d, 12), 32'd1);
        wr(STAT, 32'd1 << 12);
        pad_in[12] = 1'b0;
        edges(3);
        rd(STAT, d); check("R4 both-edge fall", bit_of(d, 12), 32'd1);
        wr(STAT, 32'd1 << 12);
        rd(STAT, d); check("R6 both-edge cleared", bit_of(d, 12), 32'd0);
        wr(caddr(12), 32'd0);
    endtask

    task automatic t_level_high();
        logic [31:0] d;
        wr(caddr(13), cw(0, 0, 1, 0, 0, 0));
        pad_in[13] = 1'b1;
        edges(3);
        rd(STAT, d); check("R4 level high sets", bit_of(d, 13), 32'd1);
        wr(STAT, 32'd1 << 13);
        rd(STAT, d); check("R5 level high re-sets after clear", bit_of(d, 13), 32'd1);
        pad_in[13] = 1'b0;
        edges(3);
        wr(STAT, 32'd1 << 13);
        rd(STAT, d); check("R5 level gone then clear sticks", bit_of(d, 13), 32'd0);
        wr(caddr(13), 32'd0);
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        wr(caddr(14), cw(1, 0, 1, 0, 0, 0));
        edges(1);
        rd(STAT, d); check("R4 level low sets", bit_of(d, 14), 32'd1);
        pad_in[14] = 1'b1;
        edges(4);
        wr(STAT, 32'd1 << 14);
        rd(STAT, d); check("R5 level low released", bit_of(d, 14), 32'd0);
        wr(caddr(14), 32'd0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        wr(caddr(15), cw(2, 0, 1, 0, 0, 0));
        pad_in[15] = 1'b1;
        edges(3);
        pad_in[15] = 1'b0;
        edges(4);
        rd(STAT, d); check("R7 pending before race", bit_of(d, 15), 32'd1);
        pad_in[15] = 1'b1;
        edges(2);
        wr(STAT, 32'd1 << 15);   // commits on the edge that sets the bit
        rd(STAT, d); check("R7 set beats clear", bit_of(d, 15), 32'd1);
        wr(STAT, 32'd1 << 15);
        rd(STAT, d); check("R6 clear after race", bit_of(d, 15), 32'd0);
        pad_in[15] = 1'b0;
        wr(caddr(15), 32'd0);
        edges(3);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(caddr(16), cw(2, 0, 0, 0, 0, 0));
        pad_in[16] = 1'b1;
        edges(4);
        rd(STAT, d); check("R8 disabled line no pending", bit_of(d, 16), 32'd0);
        check("R8 disabled line no irq", bit_of(irq_vec, 16), 32'd0);
        pad_in[16] = 1'b0;
        wr(caddr(17), cw(2, 0, 1, 0, 0, 0));
        pad_in[17] = 1'b1;
        edges(3);
        wr(caddr(17), cw(2, 0, 0, 0, 0, 0));
        check("R8 masked pending hides irq", bit_of(irq_vec, 17), 32'd0);
        rd(STAT, d); check("R8 pending kept while masked", bit_of(d, 17), 32'd1);
        wr(STAT, 32'd1 << 17);
        pad_in[17] = 1'b0;
        wr(caddr(17), 32'd0);
        wr(caddr(16), 32'd0);
        edges(3);
    endtask

    task automatic t_bad_code();
        logic [31:0] d;
        wr(caddr(18), cw(5, 0, 1, 0, 0, 0));
        pad_in[18] = 1'b1;
        edges(4);
        pad_in[18] = 1'b0;
        edges(4);
        wr(caddr(18), cw(7, 0, 1, 0, 0, 0));
        edges(2);
        rd(STAT, d); check("R4 spare codes never set", bit_of(d, 18), 32'd0);
        wr(caddr(18), 32'd0);
    endtask

    task automatic t_any();
        logic [31:0] d;
        wr(STAT, 32'hFFFF_FFFF);
        check("R9 irq_any idle", {31'd0, irq_any}, 32'd0);
        wr(caddr(20), cw(2, 0, 1, 0, 0, 0));
        pad_in[20] = 1'b1;
        edges(3);
        check("R9 irq_any raised", {31'd0, irq_any}, 32'd1);
        check("R9 irq_vec single line", irq_vec, 32'd1 << 20);
        wr(STAT, 32'd0);
        rd(STAT, d); check("R6 write zero leaves pending", d, 32'd1 << 20);
        wr(STAT, 32'd1 << 20);
        check("R9 irq_any dropped", {31'd0, irq_any}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_pads();
        t_input();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_level_low();
        t_set_wins();
        t_disabled();
        t_bad_code();
        t_any();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule